// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. Captured words are stored into an internal RAM that is addressed by a write pointer which wraps back to zero after the last location, so the newest trace always overwrites the oldest. A word-addressed register port lets software size the RAM, fill or clear it, and drain it through a read-data port that advances its own pointer on every access.

Capture runs while the capture-enable bit is set. It ends in one of three ways. Software can clear capture enable. A programmed number of words can pass after a trigger strobe. Or a manual flush that software requested can be acknowledged by the trace source. Whatever the cause, the block completes the current 4-word frame with zero words before it reports the stopped state. The write pointer therefore always rests on a frame boundary.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, offset 0x004 reads the DEPTH parameter (bit 31 clear). Read pointer (0x014), write pointer (0x018), status (0x00C), control (0x020) and formatter control (0x304) all read 0. Formatter status (0x300) reads 0x2, where bit 1 means stopped.
- R2: A read of 0x010 returns the RAM word at the read pointer and advances the read pointer by one, from DEPTH-1 to 0 on wrap. A write to 0x014 loads the read pointer.
- R3: While stopped, a write to 0x024 stores the data at the write pointer and advances it. While capture runs, such writes are ignored. A write to 0x018 while stopped loads the write pointer and clears the full flag.
- R4: Status bit 0 (full) sets when the write pointer wraps from DEPTH-1 to 0, and it stays set until the write pointer is reloaded.
- R5: A trace word with trc_valid high is stored at the write pointer only while capture runs. While stopped, trace input leaves the RAM and pointers unchanged.
- R6: With formatter control bit 13 set, a trace word that arrives in the trigger cycle is still stored. After it, exactly the number of words held in 0x01C are stored, and then capture stops. With bit 13 clear, the trigger has no effect.
- R7: Writing 1 to formatter control bit 6 raises flush_req, and bit 6 reads back as 1. Both clear on the clock edge that samples flush_done. A flush_done with no flush pending is ignored.
- R8: With formatter control bit 12 set, completion of a flush stops capture. With bit 12 clear, capture continues.
- R9: Writing 0 to control bit 0 while capture runs stops capture.
- R10: On any stop, zero words are written one per cycle until the write pointer is a multiple of 4, and no trace word is accepted meanwhile. Formatter status bit 1 rises only after that.
- R11: Writing 1 to control bit 0 while stopped restarts capture, clears formatter status bit 1 and disarms any earlier trigger.
- R12: A read of 0x010 in the same cycle as a trace store to the same RAM location returns the word held there before the store. Both pointers advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect for 0x010) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger strobe |
| flush_req | output | 1 | Manual flush pending |
| flush_done | input | 1 | Flush completion strobe from the trace source |

## Verification
A software drain through the read-data port and a trace store can hit the same cycle, and even the same RAM location. The bench provokes this by loading the read pointer with the live write pointer during capture. It then raises a read of 0x010 together with a valid trace word. The returned value must be the previously stored word, which the bench's model knows, and a later readback must show the new word. Both pointers must have advanced by exactly one.

// File: rtl/trs_pkg.sv
// Package: register offsets, control bit positions and capture state type
// shared by the circular trace sink. Assumes a 12-bit byte address bus.
package trs_pkg;
    localparam logic [11:0] A_DEPTH = 12'h004;
    localparam logic [11:0] A_STAT  = 12'h00C;
    localparam logic [11:0] A_RDATA = 12'h010;
    localparam logic [11:0] A_RPTR  = 12'h014;
    localparam logic [11:0] A_WPTR  = 12'h018;
    localparam logic [11:0] A_TRIG  = 12'h01C;
    localparam logic [11:0] A_CTRL  = 12'h020;
    localparam logic [11:0] A_WDATA = 12'h024;
    localparam logic [11:0] A_FSTAT = 12'h300;
    localparam logic [11:0] A_FCTRL = 12'h304;

    localparam int FC_FMT_EN   = 0;
    localparam int FC_FLUSH    = 6;
    localparam int FC_STOP_FL  = 12;
    localparam int FC_STOP_TRG = 13;
    localparam int FS_STOPPED  = 1;

    localparam int FRAME_WORDS = 4;

    typedef enum logic [1:0] {
        CAP_STOPPED = 2'd0,
        CAP_RUN     = 2'd1,
        CAP_PAD     = 2'd2
    } cap_state_e;
endpackage

// File: rtl/trs_wrap_ptr.sv
// Wrapping word pointer: loadable, steps by one and returns to zero after
// DEPTH-1. Load wins over step. Load values of DEPTH or more load as zero.
module trs_wrap_ptr #(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [31:0]   load_val,
    input  logic          step,
    output logic [PW-1:0] ptr,
    output logic          wrap
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    // Wrap pulse: this step takes the pointer from the last slot to zero.
    assign wrap = step && !load && (ptr == LAST);

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (load_val < 32'(DEPTH)) ? load_val[PW-1:0] : '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/trs_trace_ram.sv
// Single write port, single asynchronous read port word storage. The read
// returns the content before a same-cycle write. No reset on the array.
module trs_trace_ram #(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [PW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the addressed word.
    assign rdata = mem[raddr];

    assert_waddr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(waddr) < 32'(DEPTH)));
endmodule

// File: rtl/trs_stop_ctrl.sv
// Capture sequencer: run / pad / stopped states, post-trigger countdown and
// manual flush tracking. Assumes the write pointer alignment is fed back in.
module trs_stop_ctrl
    import trs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic        start,
    input  logic        trig,
    input  logic        stop_on_trig,
    input  logic        stop_on_flush,
    input  logic        flush_set,
    input  logic        flush_done,
    input  logic [31:0] trg_count,
    input  logic        word_acc,
    input  logic        aligned,
    output cap_state_e  state,
    output logic        stop_req,
    output logic        pad_wr,
    output logic        flush_pend
);
    logic        trig_armed;
    logic [31:0] remain;
    logic        running;
    logic        flush_fin;
    logic        trig_stop;

    assign running   = (state == CAP_RUN);
    assign flush_fin = flush_pend && flush_done;
    assign trig_stop = trig_armed && (remain == 32'd0);
    assign stop_req  = running && (!cap_en || trig_stop || (stop_on_flush && flush_fin));
    assign pad_wr    = (state == CAP_PAD) && !aligned;

    // State sequencing between capture, frame padding and stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_STOPPED;
        end else begin
            case (state)
                CAP_STOPPED: if (start) state <= CAP_RUN;
                CAP_RUN:     if (stop_req) state <= aligned ? CAP_STOPPED : CAP_PAD;
                CAP_PAD:     if (aligned) state <= CAP_STOPPED;
                default:     state <= CAP_STOPPED;
            endcase
        end
    end

    // Trigger arming and post-trigger word countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_armed <= 1'b0;
            remain     <= '0;
        end else if (start) begin
            trig_armed <= 1'b0;
        end else if (running && !trig_armed && stop_on_trig && trig) begin
            trig_armed <= 1'b1;
            remain     <= trg_count;
        end else if (word_acc && trig_armed && remain != 32'd0) begin
            remain <= remain - 32'd1;
        end
    end

    // Manual flush pending flag: set by software, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pend <= 1'b0;
        end else if (flush_fin) begin
            flush_pend <= 1'b0;
        end else if (flush_set) begin
            flush_pend <= 1'b1;
        end
    end

    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend && flush_done) |=> !flush_pend);
    assert_trig_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trig_armed && remain == 32'd0) |=> (state != CAP_RUN));
    assert_stop_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == CAP_STOPPED) |-> aligned);
    assert_flush_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_on_flush && flush_pend && flush_done) |=> (state != CAP_RUN));
endmodule

// File: rtl/trace_ring_sink.sv
// Circular trace capture buffer top: register decode, RAM write-port
// selection and full tracking. Assumes one register access per cycle and
// DEPTH a multiple of the 4-word frame.
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        trc_valid,
    input  logic [31:0] trc_data,
    input  logic        trc_trigger,
    output logic        flush_req,
    input  logic        flush_done
);
    localparam int PW = $clog2(DEPTH);

    logic          ctl_en, fmt_en_q, stop_fl_q, stop_trg_q, full_q;
    logic [31:0]   trg_q;
    cap_state_e    state;
    logic          stop_req, pad_wr, flush_pend;
    logic          stopped, trc_acc, sw_ram_wr, wptr_load, wptr_step, wwrap;
    logic          rptr_load, rptr_step, rwrap_unused;
    logic          start, flush_set, aligned;
    logic [PW-1:0] wptr, rptr;
    logic [31:0]   ram_wdata, ram_rdata;

    assign stopped   = (state == CAP_STOPPED);
    assign trc_acc   = (state == CAP_RUN) && ctl_en && trc_valid && !stop_req;
    assign sw_ram_wr = bus_wr && (bus_addr == A_WDATA) && stopped;
    assign wptr_load = bus_wr && (bus_addr == A_WPTR) && stopped;
    assign wptr_step = sw_ram_wr || trc_acc || pad_wr;
    assign rptr_load = bus_wr && (bus_addr == A_RPTR);
    assign rptr_step = bus_rd && (bus_addr == A_RDATA);
    assign start     = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0] && stopped;
    assign flush_set = bus_wr && (bus_addr == A_FCTRL) && bus_wdata[FC_FLUSH];
    assign aligned   = (wptr[1:0] == 2'b00);
    assign flush_req = flush_pend;

    // RAM write data: padding zero, then trace, then software.
    always_comb begin
        if (pad_wr)       ram_wdata = '0;
        else if (trc_acc) ram_wdata = trc_data;
        else              ram_wdata = bus_wdata;
    end

    // Software-visible control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            trg_q      <= '0;
            fmt_en_q   <= 1'b0;
            stop_fl_q  <= 1'b0;
            stop_trg_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctl_en <= bus_wdata[0];
            if (bus_addr == A_TRIG) trg_q <= bus_wdata;
            if (bus_addr == A_FCTRL) begin
                fmt_en_q   <= bus_wdata[FC_FMT_EN];
                stop_fl_q  <= bus_wdata[FC_STOP_FL];
                stop_trg_q <= bus_wdata[FC_STOP_TRG];
            end
        end
    end

    // Full flag: set on write pointer wrap, cleared by pointer reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         full_q <= 1'b0;
        else if (wptr_load) full_q <= 1'b0;
        else if (wwrap)     full_q <= 1'b1;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DEPTH: bus_rdata = 32'(DEPTH);
            A_STAT:  bus_rdata[0] = full_q;
            A_RDATA: bus_rdata = ram_rdata;
            A_RPTR:  bus_rdata = 32'(rptr);
            A_WPTR:  bus_rdata = 32'(wptr);
            A_TRIG:  bus_rdata = trg_q;
            A_CTRL:  bus_rdata[0] = ctl_en;
            A_FSTAT: bus_rdata[FS_STOPPED] = stopped;
            A_FCTRL: begin
                bus_rdata[FC_FMT_EN]   = fmt_en_q;
                bus_rdata[FC_FLUSH]    = flush_pend;
                bus_rdata[FC_STOP_FL]  = stop_fl_q;
                bus_rdata[FC_STOP_TRG] = stop_trg_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    trs_wrap_ptr #(.DEPTH(DEPTH), .PW(PW)) wptr_i (
        .clk(clk), .rst_n(rst_n), .load(wptr_load), .load_val(bus_wdata),
        .step(wptr_step), .ptr(wptr), .wrap(wwrap)
    );

    trs_wrap_ptr #(.DEPTH(DEPTH), .PW(PW)) rptr_i (
        .clk(clk), .rst_n(rst_n), .load(rptr_load), .load_val(bus_wdata),
        .step(rptr_step), .ptr(rptr), .wrap(rwrap_unused)
    );

    trs_trace_ram #(.DEPTH(DEPTH), .PW(PW)) ram_i (
        .clk(clk), .rst_n(rst_n), .we(wptr_step), .waddr(wptr),
        .wdata(ram_wdata), .raddr(rptr), .rdata(ram_rdata)
    );

    trs_stop_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .cap_en(ctl_en), .start(start),
        .trig(trc_trigger), .stop_on_trig(stop_trg_q), .stop_on_flush(stop_fl_q),
        .flush_set(flush_set), .flush_done(flush_done), .trg_count(trg_q),
        .word_acc(trc_acc), .aligned(aligned), .state(state),
        .stop_req(stop_req), .pad_wr(pad_wr), .flush_pend(flush_pend)
    );

    assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pad_wr, trc_acc, sw_ram_wr}));
    assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !wptr_load) |=> full_q);
    assert_stopped_wptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !wptr_load && !sw_ram_wr) |=> $stable(wptr));
endmodule

// File: tb/trace_ring_sink_tb_top.sv
module trace_ring_sink_tb_top;
    import trs_pkg::*;

    localparam int D = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trc_valid = 1'b0;
    logic [31:0] trc_data = '0;
    logic        trc_trigger = 1'b0;
    logic        flush_req;
    logic        flush_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] mdl [D];
    int m_w = 0;
    logic [31:0] rv;
    logic [31:0] seed_v;

    always #2 clk = ~clk;

    trace_ring_sink #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
        .flush_req(flush_req), .flush_done(flush_done)
    );

    function automatic int nxt(int p);
        return (p == D - 1) ? 0 : p + 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Model of padding to the next frame boundary.
    task automatic model_pad();
        while ((m_w % FRAME_WORDS) != 0) begin
            mdl[m_w] = '0;
            m_w = nxt(m_w);
        end
    endtask

    // Drive a random trace stream and track which words must be stored.
    task automatic run_trace(int cycles, int trig_at, bit stop_trg, int n_after);
        bit open = 1'b1;
        bit armed = 1'b0;
        int left = 0;
        for (int c = 0; c < cycles; c++) begin
            bit v;
            logic [31:0] d;
            @(negedge clk);
            v = (c == trig_at) ? 1'b1 : (($urandom % 4) != 0);
            d = $urandom;
            trc_valid = v; trc_data = d; trc_trigger = (c == trig_at);
            if (open && v) begin
                mdl[m_w] = d;
                m_w = nxt(m_w);
                if (armed) left--;
            end
            if (c == trig_at && stop_trg) begin
                armed = 1'b1;
                left = n_after;
            end
            if (armed && left == 0) open = 1'b0;
        end
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic verify_range(string req, int from, int cnt);
        wr(A_RPTR, 32'(from));
        for (int i = 0; i < cnt; i++) begin
            rchk(req, A_RDATA, mdl[(from + i) % D]);
        end
    endtask

    initial begin
        int w0;
        seed_v = $urandom(32'h5eed_1234);
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rchk("R1 depth", A_DEPTH, 32'(D));
        rchk("R1 status", A_STAT, 32'h0);
        rchk("R1 stopped", A_FSTAT, 32'h2);
        rchk("R1 rptr", A_RPTR, 32'h0);
        rchk("R1 wptr", A_WPTR, 32'h0);
        rchk("R1 ctrl", A_CTRL, 32'h0);
        rchk("R1 fctrl", A_FCTRL, 32'h0);

        // R3 / R4: fill the RAM from software
        wr(A_WPTR, 0);
        for (int i = 0; i < D; i++) begin
            mdl[i] = $urandom;
            wr(A_WDATA, mdl[i]);
            if (i == D - 2) rchk("R4 not full before wrap", A_STAT, 32'h0);
        end
        rchk("R3 wptr wrapped", A_WPTR, 32'h0);
        rchk("R4 full after wrap", A_STAT, 32'h1);
        wr(A_WPTR, 0);
        rchk("R3 reload clears full", A_STAT, 32'h0);

        // R2: read-data pops with wrap
        wr(A_RPTR, 32'(D - 2));
        rchk("R2 pop", A_RDATA, mdl[D-2]);
        rchk("R2 pop", A_RDATA, mdl[D-1]);
        rchk("R2 pop wrap", A_RDATA, mdl[0]);
        rchk("R2 rptr", A_RPTR, 32'h1);
        w0 = $urandom % D;
        verify_range("R2 random", w0, 6);

        // R5: trace ignored while stopped
        m_w = 0;
        run_trace(6, -1, 1'b0, 0);
        m_w = 0;
        rchk("R5 wptr unchanged", A_WPTR, 32'h0);
        rchk("R5 ram unchanged", A_RDATA, mdl[w0 + 6 >= D ? w0 + 6 - D : w0 + 6]);
        for (int i = 0; i < 8; i++) mdl[i] = mdl[i];

        // R6 / R10 / R11: stop after 5 post-trigger words
        wr(A_WPTR, 0); m_w = 0;
        wr(A_TRIG, 5);
        wr(A_FCTRL, 32'h2001);
        rchk("R6 fctrl readback", A_FCTRL, 32'h2001);
        wr(A_CTRL, 1);
        rchk("R11 running", A_FSTAT, 32'h0);
        run_trace(40, 7, 1'b1, 5);
        repeat (6) @(posedge clk);
        model_pad();
        rchk("R10 stopped", A_FSTAT, 32'h2);
        rchk("R6 wptr", A_WPTR, 32'(m_w));
        chk("R10 aligned", 32'(m_w % 4), 32'h0);
        verify_range("R6 R10 content", 0, m_w);

        // R6 corner: zero post-trigger words
        wr(A_WPTR, 20); m_w = 20;
        wr(A_TRIG, 0);
        wr(A_CTRL, 1);
        run_trace(20, 3, 1'b1, 0);
        repeat (6) @(posedge clk);
        model_pad();
        rchk("R6 zero count wptr", A_WPTR, 32'(m_w));
        verify_range("R6 zero count content", 20, m_w - 20);

        // R6 trigger ignored, R11 disarm, R3 write ignored while running, R9
        wr(A_WPTR, 40); m_w = 40;
        wr(A_FCTRL, 32'h0001);
        wr(A_CTRL, 1);
        run_trace(30, 5, 1'b0, 0);
        rchk("R6 R11 still running", A_FSTAT, 32'h0);
        rchk("R5 wptr follows trace", A_WPTR, 32'(m_w));
        wr(A_WDATA, 32'hDEAD_BEEF);
        rchk("R3 sw write ignored while running", A_WPTR, 32'(m_w));
        wr(A_CTRL, 0);
        repeat (6) @(posedge clk);
        model_pad();
        rchk("R9 stopped", A_FSTAT, 32'h2);
        rchk("R9 R10 wptr aligned", A_WPTR, 32'(m_w));
        verify_range("R9 content", 40, m_w - 40);

        // R7 / R8: flush with stop-on-flush
        wr(A_WPTR, 100); m_w = 100;
        wr(A_FCTRL, 32'h1001);
        wr(A_CTRL, 1);
        run_trace(9, -1, 1'b0, 0);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        rchk("R7 stray ack ignored", A_FCTRL, 32'h1001);
        rchk("R8 stray ack no stop", A_FSTAT, 32'h0);
        wr(A_FCTRL, 32'h1041);
        chk("R7 flush_req high", 32'(flush_req), 32'h1);
        rchk("R7 bit6 pending", A_FCTRL, 32'h1041);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        chk("R7 flush_req cleared", 32'(flush_req), 32'h0);
        repeat (6) @(posedge clk);
        model_pad();
        rchk("R7 bit6 cleared", A_FCTRL, 32'h1001);
        rchk("R8 stopped by flush", A_FSTAT, 32'h2);
        rchk("R8 wptr", A_WPTR, 32'(m_w));
        verify_range("R8 content", 100, m_w - 100);

        // R8 without stop bit, then R12 collision
        wr(A_FCTRL, 32'h0001);
        wr(A_CTRL, 1);
        wr(A_FCTRL, 32'h0041);
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        chk("R7 cleared no-stop flush", 32'(flush_req), 32'h0);
        rchk("R8 keeps running", A_FSTAT, 32'h0);
        w0 = m_w;
        wr(A_RPTR, 32'(w0));
        @(negedge clk);
        bus_addr = A_RDATA; bus_rd = 1'b1;
        trc_valid = 1'b1; trc_data = 32'hC0DE_0000 | 32'(w0);
        #1 rv = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; trc_valid = 1'b0;
        chk("R12 pop returns old word", rv, mdl[w0]);
        mdl[w0] = 32'hC0DE_0000 | 32'(w0);
        m_w = nxt(m_w);
        rchk("R12 rptr advanced", A_RPTR, 32'(nxt(w0)));
        rchk("R12 wptr advanced", A_WPTR, 32'(m_w));
        wr(A_CTRL, 0);
        repeat (6) @(posedge clk);
        model_pad();
        verify_range("R12 new word stored", w0, m_w - w0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule